// File: doc/BRIEF.md
# Stream-to-Memory Descriptor Chain Filler

This block is the receive half of one DMA channel. A client offers bytes in beats of up to four, each beat with a byte count and an end-of-packet marker. The block writes the accepted bytes into the buffer of the current data descriptor through a 32-bit memory port. The port uses byte enables, so any start address and any fill level are allowed. After each beat it reports how many of the offered bytes it took. The client offers the rest again later.

A descriptor is four 32-bit words:

| Byte offset | Content |
|---|---|
| 0 | Next descriptor address |
| 4 | Buffer start address |
| 8 | Flags: bit 0 end-of-list, bit 4 interrupt-enable, bit 11 input end-of-packet |
| 12 | `after`, the address one past the last buffer byte |

A descriptor closes in one of two ways: the write position reaches `after`, or a beat carries end-of-packet. On close, `after` is replaced by the real fill point, the flags word and the `after` word are written back, and raw interrupt bits are raised. The block then follows the chain to the next descriptor. If the descriptor was the last one in the list, it instead marks the channel context as disabled and halts with its end-of-list flag set.

The controller has ten states:

| State | What it does | Leaves when |
|---|---|---|
| `S_IDLE` | Waits after reset | `start_i` moves it to `S_FETCH` |
| `S_FETCH` | Reads the four descriptor words in order | The fourth read completes; goes to `S_WAIT_IN` |
| `S_WAIT_IN` | Accepts one beat | See below |
| `S_WR_LO` | Writes the first memory word of a beat | See below |
| `S_WR_HI` | Writes the second word when the beat crosses a word boundary | Goes to `S_WB_FLG` if the beat closed the descriptor, otherwise to `S_WAIT_IN` |
| `S_WB_FLG` | Writes the flags word back | Goes to `S_WB_AFT` |
| `S_WB_AFT` | Writes the `after` word back | Goes to `S_CTX_RD` on end-of-list, otherwise to `S_FETCH` of the next descriptor |
| `S_CTX_RD` | Reads the context flags word | Goes to `S_CTX_WR` |
| `S_CTX_WR` | Writes the context flags word back with its disable bit set | Goes to `S_HALT` |
| `S_HALT` | End-of-list reached | `start_i` moves it to `S_FETCH` |

From `S_WAIT_IN`, an accepted beat goes to `S_WR_LO`. A beat that takes zero bytes goes to `S_WB_FLG` if it closes the descriptor, and otherwise stays in `S_WAIT_IN`.

From `S_WR_LO`, the block goes to `S_WR_HI` if the beat crosses a word boundary. Otherwise it goes to `S_WB_FLG` if the descriptor closed, or back to `S_WAIT_IN`.

Every memory state holds its request until it is acknowledged.

Top module: `dmafill_in`

## Requirements
- R1: The accepted count equals the smaller of the offered count (`in_len_i`, clamped to 4) and `after` minus the current position. It appears on `acc_len_o`, with `acc_valid_o` high, in the cycle after the beat is taken.
- R2: While `eol_o` is high, `in_ready_o` is high and every beat reports an accepted count of 0. Such a beat leaves memory and the raw interrupts unchanged.
- R3: Accepted bytes are stored little-endian starting at the current position, with byte enables set only for accepted bytes. A beat that crosses a word boundary is written as a lower-word write followed by an upper-word write.
- R4: A descriptor closes when the position reaches `after` or when the beat carries end-of-packet. On close, the `after` word (offset 12) is rewritten with the fill position.
- R5: On close of a descriptor whose flags bit 4 is set, raw interrupt bits 0 and 1 are both set.
- R6: A beat with end-of-packet sets flags bit 11 in the written-back flags word (offset 8) and raw interrupt bit 3.
- R7: `irq_o` is the OR of `intr_raw_o & intr_mask_i`. It is re-evaluated only in a cycle where the raw value changes. `intr_clr_i` clears raw bits.
- R8: On close, the flags word is written back first and then the `after` word. What follows depends on flags bit 0:
  - If bit 0 is set, the context flags word at context address + 4 is read and written back with bit 15 set, after which `eol_o` goes high.
  - Otherwise the descriptor at the next address is fetched, and the position restarts at its buffer start.
- R9: `in_ready_o` is low while a descriptor fetch, data write, write-back or context update is in progress. A memory request holds its address and direction until `mem_ack_i`.
- R10: After reset the outputs are as follows: `in_ready_o`, `mem_req_o`, `acc_valid_o`, `eol_o`, `irq_o` and `intr_raw_o` are all 0. A `start_i` pulse in idle or halt clears `eol_o` and begins a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken in idle or halt |
| desc_addr_i | input | AW | First descriptor address |
| ctx_addr_i | input | AW | Context address |
| in_valid_i | input | 1 | Beat offered |
| in_len_i | input | LB+1 | Bytes offered (0 to 4) |
| in_data_i | input | DW | Beat bytes, first byte in bits 7:0 |
| in_eop_i | input | 1 | Beat ends a packet |
| in_ready_o | output | 1 | Beat is taken when valid and ready |
| acc_valid_o | output | 1 | Accepted-count report valid |
| acc_len_o | output | LB+1 | Bytes accepted from the last beat |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 for write |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | DW | Write data |
| mem_be_o | output | NB | Byte enables |
| mem_rdata_i | input | DW | Read data, valid with ack |
| mem_ack_i | input | 1 | Request completed |
| intr_mask_i | input | 4 | Interrupt mask |
| intr_clr_i | input | 4 | Raw interrupt clear pulse |
| intr_raw_o | output | 4 | Raw interrupt bits |
| irq_o | output | 1 | Interrupt line |
| eol_o | output | 1 | Channel reached end of list |

## Verification
The accepted count, the raw interrupt bits and `irq_o` all change on the clock edge that takes a beat. The bench therefore reads all three at the falling edge that follows that beat's acceptance. Memory contents depend on the acknowledge latency of the bench's memory model (one cycle per request). For this reason the bench never counts write cycles. Instead, before offering each beat it waits for `in_ready_o` to rise again, and it reads memory only after the chain has halted. The fetch stall is checked one falling edge after the start pulse. The re-evaluation rule is checked two cycles after a mask change that leaves the raw bits as they were.

// File: rtl/dmafill_pkg.sv
package dmafill_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH,
        S_WAIT_IN,
        S_WR_LO,
        S_WR_HI,
        S_WB_FLG,
        S_WB_AFT,
        S_CTX_RD,
        S_CTX_WR,
        S_HALT
    } fill_state_e;

    // descriptor flag bit positions (flags word, byte offset 8)
    localparam int F_EOL    = 0;
    localparam int F_INTR   = 4;
    localparam int F_IN_EOP = 11;
    // context flags word (byte offset 4): disable bit
    localparam int C_DIS    = 15;

    // descriptor word indices
    localparam int W_NEXT  = 0;
    localparam int W_BUF   = 1;
    localparam int W_FLAGS = 2;
    localparam int W_AFTER = 3;
    localparam int W_CTX_FLAGS = 1;

    // raw interrupt bits
    localparam int NIRQ     = 4;
    localparam int IRQ_D0   = 0;
    localparam int IRQ_D1   = 1;
    localparam int IRQ_EOP  = 3;

endpackage

// File: rtl/dmafill_lane.sv
module dmafill_lane #(
    parameter int AW = 32,
    parameter int NB = 4,
    localparam int LB = $clog2(NB)
) (
    input  logic [AW-1:0]     pos_i,
    input  logic [AW-1:0]     after_i,
    input  logic [LB:0]       offer_i,
    input  logic [8*NB-1:0]   data_i,
    output logic [LB:0]       take_o,
    output logic [16*NB-1:0]  dat2_o,
    output logic [2*NB-1:0]   be2_o
);

    logic [LB:0]   offer_c;
    logic [AW-1:0] remain;
    logic [NB-1:0] mask;

    always_comb begin
        offer_c = (offer_i > (LB+1)'(NB)) ? (LB+1)'(NB) : offer_i;
        remain  = after_i - pos_i;
        take_o  = (remain < AW'(offer_c)) ? remain[LB:0] : offer_c;
        for (int i = 0; i < NB; i++) begin
            mask[i] = ((LB+1)'(i) < take_o);
        end
        be2_o  = {{NB{1'b0}}, mask} << pos_i[LB-1:0];
        dat2_o = {{8*NB{1'b0}}, data_i} << {pos_i[LB-1:0], 3'b000};
    end

endmodule

// File: rtl/dmafill_irq.sv
module dmafill_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] raw_o,
    output logic         irq_o
);

    logic [N-1:0] raw_n;

    always_comb raw_n = (raw_o & ~clr_i) | set_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_o <= '0;
            irq_o <= 1'b0;
        end else begin
            raw_o <= raw_n;
            if (raw_n != raw_o) irq_o <= |(raw_n & mask_i);
        end
    end

endmodule

// File: rtl/dmafill_in.sv
module dmafill_in
    import dmafill_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    localparam int NB = DW / 8,
    localparam int LB = $clog2(NB)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [AW-1:0]   desc_addr_i,
    input  logic [AW-1:0]   ctx_addr_i,
    input  logic            in_valid_i,
    input  logic [LB:0]     in_len_i,
    input  logic [DW-1:0]   in_data_i,
    input  logic            in_eop_i,
    output logic            in_ready_o,
    output logic            acc_valid_o,
    output logic [LB:0]     acc_len_o,
    output logic            mem_req_o,
    output logic            mem_we_o,
    output logic [AW-1:0]   mem_addr_o,
    output logic [DW-1:0]   mem_wdata_o,
    output logic [NB-1:0]   mem_be_o,
    input  logic [DW-1:0]   mem_rdata_i,
    input  logic            mem_ack_i,
    input  logic [3:0]      intr_mask_i,
    input  logic [3:0]      intr_clr_i,
    output logic [3:0]      intr_raw_o,
    output logic            irq_o,
    output logic            eol_o
);

    fill_state_e st_q, st_d;

    logic [1:0]       cnt_q;
    logic [AW-1:0]    desc_q, ctx_q, next_q, buf_q, after_q, pos_q, wr_addr_q;
    logic [DW-1:0]    flags_q, ctx_w_q;
    logic [2*DW-1:0]  dat_q;
    logic [2*NB-1:0]  be_q;
    logic             done_q, eol_q, acc_v_q;
    logic [LB:0]      acc_len_q;

    // beat alignment
    logic [LB:0]      take;
    logic [2*DW-1:0]  dat2;
    logic [2*NB-1:0]  be2;

    dmafill_lane #(.AW(AW), .NB(NB)) u_lane (
        .pos_i   (pos_q),
        .after_i (after_q),
        .offer_i (in_len_i),
        .data_i  (in_data_i),
        .take_o  (take),
        .dat2_o  (dat2),
        .be2_o   (be2)
    );

    logic            fill, fin;
    logic [AW-1:0]   pos_end;
    logic [NIRQ-1:0] irq_set;

    always_comb begin
        fill    = in_valid_i && (st_q == S_WAIT_IN);
        pos_end = pos_q + AW'(take);
        fin     = (pos_end == after_q) || in_eop_i;
        irq_set = '0;
        if (fill && fin) begin
            irq_set[IRQ_D0]  = flags_q[F_INTR];
            irq_set[IRQ_D1]  = flags_q[F_INTR];
            irq_set[IRQ_EOP] = in_eop_i;
        end
    end

    dmafill_irq #(.N(NIRQ)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (irq_set),
        .clr_i  (intr_clr_i),
        .mask_i (intr_mask_i),
        .raw_o  (intr_raw_o),
        .irq_o  (irq_o)
    );

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE, S_HALT: if (start_i) st_d = S_FETCH;
            S_FETCH:  if (mem_ack_i && cnt_q == 2'd3) st_d = S_WAIT_IN;
            S_WAIT_IN: begin
                if (fill) begin
                    if (be2[NB-1:0] != '0) st_d = S_WR_LO;
                    else if (fin)          st_d = S_WB_FLG;
                end
            end
            S_WR_LO: begin
                if (mem_ack_i) begin
                    if (be_q[2*NB-1:NB] != '0) st_d = S_WR_HI;
                    else if (done_q)           st_d = S_WB_FLG;
                    else                       st_d = S_WAIT_IN;
                end
            end
            S_WR_HI:  if (mem_ack_i) st_d = done_q ? S_WB_FLG : S_WAIT_IN;
            S_WB_FLG: if (mem_ack_i) st_d = S_WB_AFT;
            S_WB_AFT: if (mem_ack_i) st_d = flags_q[F_EOL] ? S_CTX_RD : S_FETCH;
            S_CTX_RD: if (mem_ack_i) st_d = S_CTX_WR;
            S_CTX_WR: if (mem_ack_i) st_d = S_HALT;
            default:  st_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            desc_q    <= '0;
            ctx_q     <= '0;
            next_q    <= '0;
            buf_q     <= '0;
            after_q   <= '0;
            pos_q     <= '0;
            wr_addr_q <= '0;
            flags_q   <= '0;
            ctx_w_q   <= '0;
            dat_q     <= '0;
            be_q      <= '0;
            done_q    <= 1'b0;
            eol_q     <= 1'b0;
            acc_v_q   <= 1'b0;
            acc_len_q <= '0;
        end else begin
            acc_v_q   <= in_valid_i && in_ready_o;
            acc_len_q <= (st_q == S_WAIT_IN) ? take : '0;
            unique case (st_q)
                S_IDLE, S_HALT: begin
                    if (start_i) begin
                        desc_q <= desc_addr_i;
                        ctx_q  <= ctx_addr_i;
                        cnt_q  <= '0;
                        eol_q  <= 1'b0;
                    end
                end
                S_FETCH: begin
                    done_q <= 1'b0;
                    if (mem_ack_i) begin
                        cnt_q <= cnt_q + 2'd1;
                        unique case (int'(cnt_q))
                            W_NEXT:  next_q  <= mem_rdata_i;
                            W_BUF:   buf_q   <= mem_rdata_i;
                            W_FLAGS: flags_q <= mem_rdata_i;
                            default: begin
                                after_q <= mem_rdata_i;
                                pos_q   <= buf_q;
                            end
                        endcase
                    end
                end
                S_WAIT_IN: begin
                    if (fill) begin
                        pos_q     <= pos_end;
                        wr_addr_q <= {pos_q[AW-1:LB], {LB{1'b0}}};
                        dat_q     <= dat2;
                        be_q      <= be2;
                        done_q    <= fin;
                        if (fin)      after_q <= pos_end;
                        if (in_eop_i) flags_q[F_IN_EOP] <= 1'b1;
                    end
                end
                S_WB_AFT: begin
                    if (mem_ack_i && !flags_q[F_EOL]) begin
                        desc_q <= next_q;
                        cnt_q  <= '0;
                    end
                end
                S_CTX_RD: if (mem_ack_i) ctx_w_q <= mem_rdata_i | (DW'(1) << C_DIS);
                S_CTX_WR: if (mem_ack_i) eol_q <= 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        mem_be_o    = '0;
        in_ready_o  = 1'b0;
        unique case (st_q)
            S_WAIT_IN, S_HALT: in_ready_o = 1'b1;
            S_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_q + (AW'(cnt_q) << LB);
                mem_be_o   = '1;
            end
            S_WR_LO: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = wr_addr_q;
                mem_wdata_o = dat_q[DW-1:0];
                mem_be_o    = be_q[NB-1:0];
            end
            S_WR_HI: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = wr_addr_q + AW'(NB);
                mem_wdata_o = dat_q[2*DW-1:DW];
                mem_be_o    = be_q[2*NB-1:NB];
            end
            S_WB_FLG: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = desc_q + AW'(W_FLAGS * NB);
                mem_wdata_o = flags_q;
                mem_be_o    = '1;
            end
            S_WB_AFT: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = desc_q + AW'(W_AFTER * NB);
                mem_wdata_o = DW'(after_q);
                mem_be_o    = '1;
            end
            S_CTX_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = ctx_q + AW'(W_CTX_FLAGS * NB);
                mem_be_o   = '1;
            end
            S_CTX_WR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = ctx_q + AW'(W_CTX_FLAGS * NB);
                mem_wdata_o = ctx_w_q;
                mem_be_o    = '1;
            end
            default: ;
        endcase
    end

    assign acc_valid_o = acc_v_q;
    assign acc_len_o   = acc_len_q;
    assign eol_o       = eol_q;

endmodule

// File: rtl/dmafill_in_chk.sv
module dmafill_in_chk #(
    parameter int AW = 32,
    parameter int DW = 32,
    localparam int NB = DW / 8,
    localparam int LB = $clog2(NB)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid_i,
    input logic            in_ready_o,
    input logic            acc_valid_o,
    input logic [LB:0]     acc_len_o,
    input logic            mem_req_o,
    input logic            mem_we_o,
    input logic [AW-1:0]   mem_addr_o,
    input logic [NB-1:0]   mem_be_o,
    input logic            mem_ack_i,
    input logic [3:0]      intr_raw_o,
    input logic            irq_o,
    input logic            eol_o
);

    a_r1_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_o |-> (acc_len_o <= (LB+1)'(NB)));

    a_r2_zero_at_eol: assert property (@(posedge clk) disable iff (!rst_n)
        (eol_o && in_valid_i && in_ready_o) |=> (acc_valid_o && acc_len_o == '0));

    a_r2_no_mem_at_eol: assert property (@(posedge clk) disable iff (!rst_n)
        eol_o |-> !mem_req_o);

    a_r3_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> (mem_be_o != '0));

    a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_raw_o == $past(intr_raw_o)) |-> $stable(irq_o));

    a_r8_eol_after_ctx: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eol_o) |-> $past(mem_req_o && mem_we_o && mem_ack_i));

    a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !in_ready_o);

    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

endmodule

bind dmafill_in dmafill_in_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_dmafill_in.sv
module test_dmafill_in;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] desc_addr = '0, ctx_addr = '0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_len = '0;
    logic [31:0] in_data = '0;
    logic        in_eop = 1'b0;
    logic        in_ready, acc_valid;
    logic [2:0]  acc_len;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic [3:0]  mem_be;
    logic [3:0]  intr_mask = 4'b1000, intr_clr = 4'b0000, intr_raw;
    logic        irq, eol;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [512];

    always #10 clk = ~clk;

    dmafill_in i_dmafill_in (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .desc_addr_i(desc_addr), .ctx_addr_i(ctx_addr),
        .in_valid_i(in_valid), .in_len_i(in_len), .in_data_i(in_data), .in_eop_i(in_eop),
        .in_ready_o(in_ready), .acc_valid_o(acc_valid), .acc_len_o(acc_len),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_be_o(mem_be), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
        .intr_mask_i(intr_mask), .intr_clr_i(intr_clr), .intr_raw_o(intr_raw),
        .irq_o(irq), .eol_o(eol)
    );

    // memory model: one cycle acknowledge
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[10:2]];
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[10:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem[a[10:2]];
    endfunction

    typedef struct packed {
        logic [2:0]  len;
        logic [31:0] data;
        logic        eop;
        logic [2:0]  take;
        logic [3:0]  raw;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'd4, 32'h44332211, 1'b0, 3'd4, 4'h0},  // A: crosses a word
        '{3'd3, 32'h00776655, 1'b0, 3'd3, 4'h0},  // A
        '{3'd4, 32'hDDCCBBAA, 1'b0, 3'd2, 4'h3},  // A: clipped at after, intr
        '{3'd2, 32'h0000F0E1, 1'b1, 3'd2, 4'hB},  // B: early close by eop
        '{3'd4, 32'h04030201, 1'b0, 3'd4, 4'hB},  // C: last in list
        '{3'd4, 32'h99999999, 1'b1, 3'd0, 4'hB}   // halted: nothing taken
    };

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = '0;
        // descriptor A @0x100
        mem['h100 >> 2] = 32'h120; mem['h104 >> 2] = 32'h201;
        mem['h108 >> 2] = 32'h10;  mem['h10C >> 2] = 32'h20A;
        // descriptor B @0x120
        mem['h120 >> 2] = 32'h140; mem['h124 >> 2] = 32'h300;
        mem['h128 >> 2] = 32'h0;   mem['h12C >> 2] = 32'h310;
        // descriptor C @0x140 (end of list, intr)
        mem['h140 >> 2] = 32'h0;   mem['h144 >> 2] = 32'h400;
        mem['h148 >> 2] = 32'h11;  mem['h14C >> 2] = 32'h404;
        // context flags word @0x084
        mem['h084 >> 2] = 32'h80;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 ready after reset", 32'(in_ready), 32'd0);
        chk("R10 req after reset", 32'(mem_req), 32'd0);
        chk("R10 eol after reset", 32'(eol), 32'd0);
        chk("R10 irq/raw after reset", {27'd0, irq, intr_raw}, 32'd0);
        chk("R10 acc_valid after reset", 32'(acc_valid), 32'd0);

        start = 1'b1; desc_addr = 32'h100; ctx_addr = 32'h080;
        @(negedge clk);
        start = 1'b0;
        chk("R9 stalled during fetch", 32'(in_ready), 32'd0);

        for (int v = 0; v < 6; v++) begin
            @(negedge clk);
            in_valid = 1'b1; in_len = VECS[v].len; in_data = VECS[v].data; in_eop = VECS[v].eop;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0; in_eop = 1'b0;
            chk($sformatf("R1 acc_valid vec %0d", v), 32'(acc_valid), 32'd1);
            chk($sformatf("R1/R2 take vec %0d", v), 32'(acc_len), 32'(VECS[v].take));
            chk($sformatf("R5/R6 raw vec %0d", v), 32'(intr_raw), 32'(VECS[v].raw));
        end

        chk("R8 halted at end of list", 32'(eol), 32'd1);
        chk("R3 unaligned first word", rd(32'h200), 32'h33221100);
        chk("R3 second word", rd(32'h204), 32'h77665544);
        chk("R1 clipped word", rd(32'h208), 32'h0000BBAA);
        chk("R4 A after rewritten", rd(32'h10C), 32'h20A);
        chk("R8 A flags written back", rd(32'h108), 32'h10);
        chk("R6 B flags in_eop", rd(32'h128), 32'h800);
        chk("R4 B after early close", rd(32'h12C), 32'h302);
        chk("R3 B data", rd(32'h300), 32'h0000F0E1);
        chk("R8 C data via chain", rd(32'h400), 32'h04030201);
        chk("R4 C after", rd(32'h14C), 32'h404);
        chk("R8 context disable bit", rd(32'h084), 32'h8080);
        chk("R2 no write at halt", rd(32'h404), 32'h0);
        chk("R7 irq from masked eop bit", 32'(irq), 32'd1);

        intr_mask = 4'b0000;
        repeat (2) @(negedge clk);
        chk("R7 no re-evaluation on mask change", 32'(irq), 32'd1);
        intr_clr = 4'b1000;
        @(negedge clk);
        intr_clr = 4'b0000;
        chk("R7 clear raw bit 3", 32'(intr_raw), 32'h3);
        chk("R7 re-evaluated on raw change", 32'(irq), 32'd0);

        start = 1'b1; desc_addr = 32'h100;
        @(negedge clk);
        start = 1'b0;
        chk("R10 start clears eol", 32'(eol), 32'd0);
        chk("R9 restart fetch stalls input", 32'(in_ready), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule